// File: doc/BRIEF.md
# Composite Memory Select Combiner

This block merges the active-low chip-select strobes of four memory spaces (program, data, boot and I/O) into one composite select. A software-written enable mask chooses which of the four strobes can pull the composite low. One physical memory can then answer in several spaces at once, with the composite driving its chip select. The path from any strobe to the composite is purely combinational, so the composite has exactly the same timing as the strobe that causes it.

A second register, the system control word, holds a boot-select disable flag. While that flag is set, the boot strobe is held high at its own output, so booting and bulk transfers can target different devices. The boot strobe's effect on the composite still depends only on its enable bit. The other three strobes pass to their outputs unchanged.

The strobes and selects are level signals, not a data stream. No valid/ready handshake is involved and there is no back-pressure. Register writes are single-cycle strobes that are always accepted.

Top module: `cms_top`

## Requirements
- R1: Strobes are active low and indexed as follows: bit 0 program, bit 1 data, bit 2 boot, bit 3 I/O. Enable bit i governs strobe bit i.
- R2: When a strobe is low and its enable bit is 1, `comp_sel_n` is low in the same cycle, with no register on the path.
- R3: `comp_sel_n` is low only when at least one enabled strobe is low. With every enable bit at 0 it stays high for all strobe patterns.
- R4: After reset the enable mask is 4'b1011 (boot bit clear, all others set) and the boot disable flag is 0.
- R5: A write with `cfg_addr` = 0 loads the enable mask from `cfg_wdata[3:0]` at the clock edge. The new mask takes effect from the next cycle, and `cfg_wdata[7:4]` is ignored.
- R6: A write with `cfg_addr` = 1 loads the boot disable flag from `cfg_wdata[3]`. While the flag is 1, `sel_out_n[2]` is held high. While it is 0, `sel_out_n[2]` follows `sel_n[2]`.
- R7: `sel_out_n` bits 0, 1 and 3 equal the matching `sel_n` bits in the same cycle, whatever the register contents.
- R8: The boot strobe's effect on `comp_sel_n` depends only on enable bit 2 and does not depend on the disable flag.
- R9: When `cfg_we` is 0, neither register changes, whatever `cfg_addr` and `cfg_wdata` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 1 | 0 selects the enable mask, 1 selects the system control word |
| cfg_wdata | input | 8 | Register write data |
| sel_n | input | 4 | Raw active-low strobes (program, data, boot, I/O) |
| comp_sel_n | output | 1 | Active-low composite select |
| sel_out_n | output | 4 | Active-low strobes after boot-disable gating |

## Verification
Several behaviours are checked on every clock edge: enabled low strobes forcing the composite low, the composite never going low without an enabled low strobe, the gated boot output being held high while disabled, the other outputs mirroring their strobes, and register loads and holds. Only the bench scenarios can show the reset mask values, that the upper data bits are ignored, that the mask takes effect one cycle after a write, and how the disable flag and the boot enable combine. The bench shows these through pattern walks at the ports.

// File: rtl/cms_pkg.sv
package cms_pkg;
  localparam int NUM_SEL      = 4;
  localparam int CFG_W        = 8;
  localparam int IDX_PROG     = 0;
  localparam int IDX_DATA     = 1;
  localparam int IDX_BOOT     = 2;
  localparam int IDX_IO       = 3;
  localparam int BOOT_DIS_BIT = 3;
  localparam logic [NUM_SEL-1:0] EN_RST = 4'b1011;

  typedef enum logic {
    CFG_ENABLE = 1'b0,
    CFG_SYSCTL = 1'b1
  } cfg_addr_e;
endpackage

// File: rtl/cms_cfg_regs.sv
module cms_cfg_regs #(
  parameter int NUM_SEL      = cms_pkg::NUM_SEL,
  parameter int CFG_W        = cms_pkg::CFG_W,
  parameter int BOOT_DIS_BIT = cms_pkg::BOOT_DIS_BIT,
  parameter logic [NUM_SEL-1:0] EN_RST = cms_pkg::EN_RST
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic               addr,
  input  logic [CFG_W-1:0]   wdata,
  output logic [NUM_SEL-1:0] en_q,
  output logic               boot_dis_q
);
  import cms_pkg::*;

  logic wr_en_reg, wr_ctl_reg;
  assign wr_en_reg  = we && (addr == CFG_ENABLE);
  assign wr_ctl_reg = we && (addr == CFG_SYSCTL);

  // bits of the write word that neither register stores
  logic unused_wdata;
  assign unused_wdata = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= EN_RST;
    end else if (wr_en_reg) begin
      en_q <= wdata[NUM_SEL-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_dis_q <= 1'b0;
    end else if (wr_ctl_reg) begin
      boot_dis_q <= wdata[BOOT_DIS_BIT];
    end
  end
endmodule

// File: rtl/cms_sel_gate.sv
module cms_sel_gate #(
  parameter int NUM_SEL  = cms_pkg::NUM_SEL,
  parameter int BOOT_IDX = cms_pkg::IDX_BOOT
) (
  input  logic [NUM_SEL-1:0] sel_n,
  input  logic               boot_dis,
  output logic [NUM_SEL-1:0] sel_out_n
);
  for (genvar i = 0; i < NUM_SEL; i++) begin : g_lane
    if (i == BOOT_IDX) begin : g_boot
      // a disabled boot strobe is forced to its inactive (high) level
      assign sel_out_n[i] = sel_n[i] | boot_dis;
    end else begin : g_pass
      assign sel_out_n[i] = sel_n[i];
    end
  end
endmodule

// File: rtl/cms_combine.sv
module cms_combine #(
  parameter int NUM_SEL = cms_pkg::NUM_SEL
) (
  input  logic [NUM_SEL-1:0] sel_n,
  input  logic [NUM_SEL-1:0] en,
  output logic               comp_sel_n
);
  logic [NUM_SEL-1:0] hit;

  for (genvar i = 0; i < NUM_SEL; i++) begin : g_hit
    assign hit[i] = ~sel_n[i] & en[i];
  end

  assign comp_sel_n = ~(|hit);
endmodule

// File: rtl/cms_top.sv
module cms_top #(
  parameter int NUM_SEL      = cms_pkg::NUM_SEL,
  parameter int CFG_W        = cms_pkg::CFG_W,
  parameter int BOOT_IDX     = cms_pkg::IDX_BOOT,
  parameter int BOOT_DIS_BIT = cms_pkg::BOOT_DIS_BIT,
  parameter logic [NUM_SEL-1:0] EN_RST = cms_pkg::EN_RST
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic               cfg_addr,
  input  logic [CFG_W-1:0]   cfg_wdata,
  input  logic [NUM_SEL-1:0] sel_n,
  output logic               comp_sel_n,
  output logic [NUM_SEL-1:0] sel_out_n
);
  logic [NUM_SEL-1:0] en_q;
  logic               boot_dis_q;

  cms_cfg_regs #(
    .NUM_SEL(NUM_SEL), .CFG_W(CFG_W),
    .BOOT_DIS_BIT(BOOT_DIS_BIT), .EN_RST(EN_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .en_q(en_q), .boot_dis_q(boot_dis_q)
  );

  // the composite takes the raw strobes: boot gating does not touch it
  cms_combine #(.NUM_SEL(NUM_SEL)) u_comb (
    .sel_n(sel_n), .en(en_q), .comp_sel_n(comp_sel_n)
  );

  cms_sel_gate #(.NUM_SEL(NUM_SEL), .BOOT_IDX(BOOT_IDX)) u_gate (
    .sel_n(sel_n), .boot_dis(boot_dis_q), .sel_out_n(sel_out_n)
  );
endmodule

// File: rtl/cms_chk.sv
module cms_chk #(
  parameter int NUM_SEL  = 4,
  parameter int CFG_W    = 8,
  parameter int BOOT_IDX = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_we,
  input logic               cfg_addr,
  input logic [CFG_W-1:0]   cfg_wdata,
  input logic [NUM_SEL-1:0] sel_n,
  input logic               comp_sel_n,
  input logic [NUM_SEL-1:0] sel_out_n,
  input logic [NUM_SEL-1:0] en_q,
  input logic               boot_dis_q
);
  for (genvar i = 0; i < NUM_SEL; i++) begin : g_lane
    // R2: enabled low strobe drives the composite low
    a_r2_enabled_low_pulls: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_n[i] && en_q[i]) |-> !comp_sel_n);
    if (i != BOOT_IDX) begin : g_pass
      // R7: non-boot outputs mirror their strobes
      a_r7_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        sel_out_n[i] == sel_n[i]);
    end
  end

  // R3: composite low needs an enabled low strobe
  a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !comp_sel_n |-> (|(~sel_n & en_q)));

  // R6: boot output held high while disabled
  a_r6_boot_held: assert property (@(posedge clk) disable iff (!rst_n)
    boot_dis_q |-> sel_out_n[BOOT_IDX]);

  // R5: mask write lands on the next cycle
  a_r5_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_addr) |=> (en_q == $past(cfg_wdata[NUM_SEL-1:0])));

  // R9: no write, no change
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ($stable(en_q) && $stable(boot_dis_q)));
endmodule

bind cms_top cms_chk #(.NUM_SEL(NUM_SEL), .CFG_W(CFG_W), .BOOT_IDX(BOOT_IDX)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .sel_n(sel_n), .comp_sel_n(comp_sel_n),
  .sel_out_n(sel_out_n), .en_q(en_q), .boot_dis_q(boot_dis_q)
);

// File: tb/sim_cms_top.sv
`timescale 1ns/1ps
module sim_cms_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic       cfg_addr = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [3:0] sel_n = 4'hF;
  logic       comp_sel_n;
  logic [3:0] sel_out_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cms_top u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .sel_n(sel_n), .comp_sel_n(comp_sel_n),
    .sel_out_n(sel_out_n)
  );

  // fields: en[13:10] dis[9] sel[8:5] exp_comp[4] exp_out[3:0]
  localparam logic [13:0] VEC [10] = '{
    {4'b1011, 1'b0, 4'b1110, 1'b0, 4'b1110}, // R2 program low, enabled
    {4'b1011, 1'b0, 4'b1011, 1'b1, 4'b1011}, // R3 boot low, not enabled
    {4'b0100, 1'b0, 4'b1011, 1'b0, 4'b1011}, // R2 boot enabled
    {4'b0100, 1'b1, 4'b1011, 1'b0, 4'b1111}, // R8 disabled boot still feeds composite
    {4'b0000, 1'b0, 4'b0000, 1'b1, 4'b0000}, // R3 empty mask
    {4'b1000, 1'b0, 4'b0111, 1'b0, 4'b0111}, // R1 I/O on bit 3
    {4'b1000, 1'b0, 4'b1000, 1'b1, 4'b1000}, // R3 only unenabled lows
    {4'b1111, 1'b1, 4'b0000, 1'b0, 4'b0100}, // R6 boot output held high
    {4'b0011, 1'b1, 4'b0011, 1'b1, 4'b0111}, // R7 mirror with gating
    {4'b1111, 1'b0, 4'b1111, 1'b1, 4'b1111}  // R3 idle
  };

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got comp=%b out=%b, expected comp=%b out=%b",
               req, act[4], act[3:0], exp[4], exp[3:0]);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic probe(input logic [3:0] s);
    sel_n = s;
    #0.5;
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R4: reset mask 1011, disable 0
    probe(4'b1011); check("R4 boot not enabled", {comp_sel_n, sel_out_n}, {1'b1, 4'b1011});
    probe(4'b1110); check("R4 program enabled", {comp_sel_n, sel_out_n}, {1'b0, 4'b1110});
    probe(4'b1101); check("R4 data enabled", {comp_sel_n, sel_out_n}, {1'b0, 4'b1101});
    probe(4'b0111); check("R4 io enabled", {comp_sel_n, sel_out_n}, {1'b0, 4'b0111});

    for (int k = 0; k < 10; k++) begin
      wr(1'b0, {4'h0, VEC[k][13:10]});
      wr(1'b1, {4'h0, VEC[k][9], 3'b000});
      probe(VEC[k][8:5]);
      check($sformatf("R1/R2/R3/R6/R7/R8 vector %0d", k), {comp_sel_n, sel_out_n}, VEC[k][4:0]);
      // R2: composite tracks a strobe change with no cycle of delay
      probe(4'hF);
      check($sformatf("R2 release vector %0d", k), {comp_sel_n, sel_out_n}, {1'b1, 4'hF});
    end

    // R5: upper data bits ignored; mask applies on the cycle after the write
    wr(1'b0, 8'hF0);
    probe(4'b0000); check("R5 upper bits ignored", {comp_sel_n, sel_out_n}, {1'b1, 4'b0000});
    @(negedge clk);
    sel_n = 4'b1110;
    cfg_we = 1'b1; cfg_addr = 1'b0; cfg_wdata = 8'h01;
    #0.5; check("R5 before edge", {comp_sel_n, sel_out_n}, {1'b1, 4'b1110});
    @(negedge clk); cfg_we = 1'b0;
    #0.5; check("R5 after edge", {comp_sel_n, sel_out_n}, {1'b0, 4'b1110});

    // R9: data on the bus without cfg_we changes nothing
    cfg_addr = 1'b0; cfg_wdata = 8'h00;
    repeat (2) @(negedge clk);
    cfg_addr = 1'b1; cfg_wdata = 8'hFF;
    repeat (2) @(negedge clk);
    probe(4'b1010);
    check("R9 writes ignored without cfg_we", {comp_sel_n, sel_out_n}, {1'b0, 4'b1010});

    // R6: only bit 3 of the control word matters
    wr(1'b1, 8'hF7);
    probe(4'b1011); check("R6 bit3 clear leaves boot live", {comp_sel_n, sel_out_n}, {1'b1, 4'b1011});
    wr(1'b1, 8'h08);
    probe(4'b1011); check("R6 bit3 set holds boot high", {comp_sel_n, sel_out_n}, {1'b1, 4'b1111});

    // R4: a second reset restores the defaults
    rst_n = 1'b0; #1; rst_n = 1'b1;
    @(negedge clk);
    probe(4'b1011); check("R4 reset again", {comp_sel_n, sel_out_n}, {1'b1, 4'b1011});

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule